// File: doc/BRIEF.md
# Two-Level Microprogram Sequencer with Shared Class Branching

This block sequences a fixed microprogram laid out as linear chains of steps. A microinstruction address is the concatenation of a 3-bit chain number (upper bits) and a 2-bit step number (lower bits). Inside a chain the step counter advances by one each cycle. When the last step of a chain is reached, the next address is taken from branch logic that looks at a class code rather than at the chain number. Chains that lead to the same successor share one class, so they share one set of branch terms.

Storage is split in two levels. A narrow micromemory holds a 3-bit collection code per address, plus one spare bit. That spare bit is set only at the last step of a chain and supplies the class code's top bit. A second, small table expands the collection code into the microoperation lines. The expansion also yields two control flags: "advance" (stay in the chain) and "end" (stop fetching). The remaining two class bits come from a chain-to-class table indexed by the current chain number. A one-cycle `start` pulse launches the program at address 0. From then on the block emits one microoperation set per cycle until the end flag is read.

Top module: `mcu_seq`

## Requirements
- R1: After reset `fetch` is 0 and `mo` is all zeros.
- R2: `start` high at a clock edge loads address 00000 and sets `fetch`. This holds whatever else that cycle would do: advance, branch or end.
- R3: The current address is {chain[2:0], step[1:0]}. While `fetch` is 1, a microinstruction whose collection carries the advance flag leads to chain unchanged, step + 1 at the next edge.
- R4: Chain lengths for chains 0..7 are 3,4,2,3,4,3,2,3. Non-last step s of chain c holds code {0,1,3,4}[(c+s) mod 4]. The last step holds code 7 for chain 7 and {2,5,6}[c mod 3] otherwise.
- R5: Code expansion: 0→{adv,y1,y2}, 1→{adv,y3,y9}, 2→{y4}, 3→{adv,y3,y5}, 4→{adv,y3,y6}, 5→{y1,y7}, 6→{y8}, 7→{y1,y2,end}. Output bit `mo[n]` carries yn; the advance and end flags do not appear on `mo`.
- R6: At a chain's last step the class code is {spare, t1, t0}. The spare bit is 1 only for chain 6. Chain to {t1,t0} is: 0→00, 1→01, 2→01, 3→10, 4→10, 5→11, 6→00.
- R7: Class 000 branches to 00100 if x[1], else to 01000. Class 001 branches to 01100 if x[3]; otherwise to 10000 if x[4]; otherwise to 10100.
- R8: Class 010 branches to 10100 if x[2]; otherwise to 11000 if x[3]; otherwise to 10101. Class 011 always goes to 11000. Class 100 goes to 11100 if x[1], else to 01101. At most one of the 11 branch terms is active at a time.
- R9: Reading a collection with the end flag clears `fetch` at the next edge. While `fetch` is 0, `mo` is all zeros and the address holds, whatever `x` does.
- R10: `x` affects the sequence only at chain last steps; during advance steps any `x` value gives the same next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch the microprogram at address 0 |
| x | input | 4 | Logical condition inputs x[4:1] |
| fetch | output | 1 | Program is running |
| mo | output | 9 | Microoperations y9..y1 of the current step |

## Verification
Two functions can fall in the same cycle: a restart and the step's own successor choice. That choice is a class branch at a chain exit, or the stop at the end step. The bench provokes the clash by raising `start` exactly at the k-th chain exit of a run, for several k, and at the end step. An independent arithmetic model of the plain chain/step sequencer runs alongside the design. The cycle after each clash is judged: `mo` must show the word at address 00000 and `fetch` must stay 1, not the branch target or a stopped unit.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    localparam int CHAIN_W = 3;
    localparam int STEP_W  = 2;
    localparam int COLL_W  = 3;
    localparam int CLASS_W = 3;
    localparam int SLICE_W = 2;
    localparam int X_W     = 4;
    localparam int MO_N    = 9;

    // expanded microinstruction: advance flag, end flag, data-path lines
    typedef struct packed {
        logic            adv;
        logic            fin;
        logic [MO_N:1]   mo;
    } ops_t;

    // number of steps in each chain
    function automatic int chain_len(input int c);
        case (c)
            0: return 3;
            1: return 4;
            2: return 2;
            3: return 3;
            4: return 4;
            5: return 3;
            6: return 2;
            default: return 3;
        endcase
    endfunction

    // collection code stored at step s of chain c
    function automatic logic [COLL_W-1:0] coll_at(input int c, input int s);
        int len;
        len = chain_len(c);
        if (s >= len) return COLL_W'(2);
        if (s == len - 1) begin
            if (c == 7) return COLL_W'(7);
            case (c % 3)
                0: return COLL_W'(2);
                1: return COLL_W'(5);
                default: return COLL_W'(6);
            endcase
        end
        case ((c + s) % 4)
            0: return COLL_W'(0);
            1: return COLL_W'(1);
            2: return COLL_W'(3);
            default: return COLL_W'(4);
        endcase
    endfunction

    // class of the successor group a chain belongs to
    function automatic logic [CLASS_W-1:0] class_of(input int c);
        case (c)
            0: return CLASS_W'(0);
            1: return CLASS_W'(1);
            2: return CLASS_W'(1);
            3: return CLASS_W'(2);
            4: return CLASS_W'(2);
            5: return CLASS_W'(3);
            6: return CLASS_W'(4);
            default: return CLASS_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/mcu_umem.sv
module mcu_umem
    import mcu_pkg::*;
#(
    parameter int CW = CHAIN_W,
    parameter int SW = STEP_W,
    parameter int KW = COLL_W,
    parameter int LW = SLICE_W
) (
    input  logic [CW+SW-1:0]        addr,
    output logic [KW-1:0]           coll,
    output logic [((KW+LW)/LW)*LW-KW-1:0] spare
);
    localparam int ADDR_W  = CW + SW;
    localparam int N_SLICE = (KW + LW) / LW;
    localparam int WORD_W  = N_SLICE * LW;

    function automatic logic [WORD_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        int c;
        int s;
        logic [WORD_W-1:0] w;
        logic [CLASS_W-1:0] k;
        c = int'(a[ADDR_W-1:SW]);
        s = int'(a[SW-1:0]);
        w = '0;
        w[KW-1:0] = coll_at(c, s);
        k = class_of(c);
        if (s == chain_len(c) - 1)
            w[KW] = 1'(k >> (CLASS_W - 1));
        return w;
    endfunction

    function automatic logic [LW-1:0] slice_at(input logic [ADDR_W-1:0] a, input int k);
        return LW'(word_at(a) >> (k * LW));
    endfunction

    logic [WORD_W-1:0] word;

    for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
        logic [LW-1:0] bits_d;
        always_comb bits_d = slice_at(addr, k);
        assign word[k*LW +: LW] = bits_d;
    end

    assign coll  = word[KW-1:0];
    assign spare = word[WORD_W-1:KW];

endmodule

// File: rtl/mcu_opdec.sv
module mcu_opdec
    import mcu_pkg::*;
#(
    parameter int KW = COLL_W
) (
    input  logic [KW-1:0] coll,
    output ops_t          ops
);
    always_comb begin
        ops = '0;
        case (coll)
            KW'(0): begin ops.adv = 1'b1; ops.mo[1] = 1'b1; ops.mo[2] = 1'b1; end
            KW'(1): begin ops.adv = 1'b1; ops.mo[3] = 1'b1; ops.mo[9] = 1'b1; end
            KW'(2): begin ops.mo[4] = 1'b1; end
            KW'(3): begin ops.adv = 1'b1; ops.mo[3] = 1'b1; ops.mo[5] = 1'b1; end
            KW'(4): begin ops.adv = 1'b1; ops.mo[3] = 1'b1; ops.mo[6] = 1'b1; end
            KW'(5): begin ops.mo[1] = 1'b1; ops.mo[7] = 1'b1; end
            KW'(6): begin ops.mo[8] = 1'b1; end
            default: begin ops.fin = 1'b1; ops.mo[1] = 1'b1; ops.mo[2] = 1'b1; end
        endcase
    end

endmodule

// File: rtl/mcu_xform.sv
module mcu_xform
    import mcu_pkg::*;
#(
    parameter int CW = CHAIN_W,
    parameter int OW = 2
) (
    input  logic [CW-1:0] chain,
    output logic [OW-1:0] cls_lo
);
    always_comb cls_lo = OW'(class_of(int'(chain)));

endmodule

// File: rtl/mcu_nextaddr.sv
module mcu_nextaddr
    import mcu_pkg::*;
#(
    parameter int CW = CHAIN_W,
    parameter int SW = STEP_W,
    parameter int KW = CLASS_W,
    parameter int XW = X_W
) (
    input  logic [KW-1:0]    cls,
    input  logic [XW:1]      x,
    output logic [CW+SW-1:0] target,
    output logic             hit
);
    localparam int ADDR_W = CW + SW;
    localparam int N_TERM = 11;

    localparam logic [KW-1:0] T_CLS [N_TERM] = '{
        KW'(0), KW'(0), KW'(1), KW'(1), KW'(1), KW'(2), KW'(2), KW'(2),
        KW'(3), KW'(4), KW'(4)};
    localparam logic [XW:1] T_MASK [N_TERM] = '{
        XW'(4'b0001), XW'(4'b0001), XW'(4'b0100), XW'(4'b1100), XW'(4'b1100),
        XW'(4'b0010), XW'(4'b0110), XW'(4'b0110), XW'(4'b0000),
        XW'(4'b0001), XW'(4'b0001)};
    localparam logic [XW:1] T_VAL [N_TERM] = '{
        XW'(4'b0001), XW'(4'b0000), XW'(4'b0100), XW'(4'b1000), XW'(4'b0000),
        XW'(4'b0010), XW'(4'b0100), XW'(4'b0000), XW'(4'b0000),
        XW'(4'b0001), XW'(4'b0000)};
    localparam logic [ADDR_W-1:0] T_TGT [N_TERM] = '{
        ADDR_W'(5'b00100), ADDR_W'(5'b01000), ADDR_W'(5'b01100),
        ADDR_W'(5'b10000), ADDR_W'(5'b10100), ADDR_W'(5'b10100),
        ADDR_W'(5'b11000), ADDR_W'(5'b10101), ADDR_W'(5'b11000),
        ADDR_W'(5'b11100), ADDR_W'(5'b01101)};

    logic [N_TERM-1:0] terms;

    for (genvar i = 0; i < N_TERM; i++) begin : g_term
        assign terms[i] = (cls == T_CLS[i]) && ((x & T_MASK[i]) == T_VAL[i]);
    end

    always_comb begin
        target = '0;
        for (int i = 0; i < N_TERM; i++)
            if (terms[i]) target = target | T_TGT[i];
    end

    assign hit = |terms;

    // R8
    always_comb begin
        if (!$isunknown({cls, x}))
            term_onehot_chk: assert ($onehot0(terms));
    end

endmodule

// File: rtl/mcu_seq.sv
module mcu_seq
    import mcu_pkg::*;
#(
    parameter int CW = CHAIN_W,
    parameter int SW = STEP_W,
    parameter int KW = COLL_W,
    parameter int LW = SLICE_W,
    parameter int CLW = CLASS_W,
    parameter int XW = X_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [XW:1]   x,
    output logic          fetch,
    output logic [MO_N:1] mo
);
    localparam int ADDR_W  = CW + SW;
    localparam int N_SLICE = (KW + LW) / LW;
    localparam int SPARE_W = N_SLICE * LW - KW;
    localparam int LOW_W   = CLW - SPARE_W;

    typedef struct packed {
        logic          run;
        logic [CW-1:0] rg;
        logic [SW-1:0] ct;
    } seq_t;

    seq_t q, d;

    logic [KW-1:0]      coll;
    logic [SPARE_W-1:0] spare;
    logic [LOW_W-1:0]   cls_lo;
    logic [CLW-1:0]     cls;
    logic [ADDR_W-1:0]  target;
    logic               hit;
    ops_t               ops;

    mcu_umem #(.CW(CW), .SW(SW), .KW(KW), .LW(LW)) u_umem (
        .addr  ({q.rg, q.ct}),
        .coll  (coll),
        .spare (spare)
    );

    mcu_opdec #(.KW(KW)) u_opdec (
        .coll (coll),
        .ops  (ops)
    );

    mcu_xform #(.CW(CW), .OW(LOW_W)) u_xform (
        .chain  (q.rg),
        .cls_lo (cls_lo)
    );

    assign cls = {spare, cls_lo};

    mcu_nextaddr #(.CW(CW), .SW(SW), .KW(CLW), .XW(XW)) u_next (
        .cls    (cls),
        .x      (x),
        .target (target),
        .hit    (hit)
    );

    always_comb begin
        d = q;
        if (start) begin
            d.run = 1'b1;
            d.rg  = '0;
            d.ct  = '0;
        end else if (q.run) begin
            if (ops.fin)
                d.run = 1'b0;
            else if (ops.adv)
                d.ct = q.ct + 1'b1;
            else
                {d.rg, d.ct} = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fetch = q.run;
    assign mo    = q.run ? ops.mo : '0;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.run && q.rg == '0 && q.ct == '0));

    // R3
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && ops.adv && !start) |=> (q.ct == $past(q.ct) + 1'b1 && $stable(q.rg)));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && ops.fin && !start) |=> !q.run);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !start) |=> (!q.run && $stable(q.rg) && $stable(q.ct)));

    // R6
    class_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !ops.adv && !ops.fin) |-> hit);

endmodule

// File: tb/tb_mcu_seq.sv
module tb_mcu_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:1] x = '0;
    logic       fetch;
    logic [9:1] mo;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mcu_seq dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .x     (x),
        .fetch (fetch),
        .mo    (mo)
    );

    // reference model of the plain chain/step sequencer
    logic       m_run = 1'b0;
    int         m_c = 0;
    int         m_s = 0;
    string      tag = "R1";

    function automatic int b_len(input int c);
        int t [8] = '{3, 4, 2, 3, 4, 3, 2, 3};
        return t[c];
    endfunction

    function automatic int b_code(input int c, input int s);
        int ex [3] = '{2, 5, 6};
        int rn [4] = '{0, 1, 3, 4};
        if (s == b_len(c) - 1) return (c == 7) ? 7 : ex[c % 3];
        return rn[(c + s) % 4];
    endfunction

    // returns {adv, fin, y9..y1}
    function automatic logic [10:0] b_ops(input int code);
        logic [9:1] y;
        logic a, f;
        y = '0; a = 1'b0; f = 1'b0;
        case (code)
            0: begin a = 1; y[1] = 1; y[2] = 1; end
            1: begin a = 1; y[3] = 1; y[9] = 1; end
            2: y[4] = 1;
            3: begin a = 1; y[3] = 1; y[5] = 1; end
            4: begin a = 1; y[3] = 1; y[6] = 1; end
            5: begin y[1] = 1; y[7] = 1; end
            6: y[8] = 1;
            default: begin f = 1; y[1] = 1; y[2] = 1; end
        endcase
        return {a, f, y};
    endfunction

    function automatic int b_class(input int c);
        int t [8] = '{0, 1, 1, 2, 2, 3, 4, 0};
        return t[c];
    endfunction

    function automatic int b_branch(input int k, input logic [4:1] xv);
        case (k)
            0: return xv[1] ? 5'b00100 : 5'b01000;
            1: return xv[3] ? 5'b01100 : (xv[4] ? 5'b10000 : 5'b10100);
            2: return xv[2] ? 5'b10100 : (xv[3] ? 5'b11000 : 5'b10101);
            3: return 5'b11000;
            default: return xv[1] ? 5'b11100 : 5'b01101;
        endcase
    endfunction

    task automatic chk(input logic ok, input string t, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    function automatic logic [10:0] cur_ops();
        return m_run ? b_ops(b_code(m_c, m_s)) : 11'd0;
    endfunction

    // one cycle: check outputs of the present state, then drive and advance model
    task automatic cyc(input logic st, input logic [4:1] xv);
        logic [10:0] o;
        int a;
        @(negedge clk);
        o = cur_ops();
        chk(fetch === m_run, tag, "fetch", int'(fetch), int'(m_run));
        chk(mo === o[8:0], tag, "mo", int'(mo), int'(o[8:0]));
        start = st;
        x = xv;
        if (st) begin
            m_run = 1; m_c = 0; m_s = 0; tag = "R2";
        end else if (!m_run) begin
            tag = "R9";
        end else if (o[9]) begin
            m_run = 0; tag = "R9 R4 R5";
        end else if (o[10]) begin
            m_s = m_s + 1; tag = "R3 R4 R5 R10";
        end else begin
            a = b_branch(b_class(m_c), xv);
            tag = (b_class(m_c) < 2) ? "R7 R6 R4" : "R8 R6 R4";
            m_c = a >> 2; m_s = a & 3;
        end
    endtask

    function automatic logic at_exit();
        logic [10:0] o;
        o = cur_ops();
        return m_run && !o[10];
    endfunction

    // run the program: mode 0 holds x, mode 1 random x; restart at k-th exit
    task automatic run(input int mode, input logic [4:1] xf, input int k);
        int exits = 0;
        logic [4:1] xv;
        cyc(1'b1, xf);
        for (int i = 0; i < 40 && m_run; i++) begin
            logic st;
            xv = (mode == 1) ? 4'($urandom) : xf;
            st = 1'b0;
            if (at_exit()) begin
                exits++;
                if (exits == k) begin st = 1'b1; tag = "R2"; end
            end
            cyc(st, xv);
        end
        for (int i = 0; i < 3; i++) cyc(1'b0, 4'($urandom));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, then R9 idle with x toggling
        tag = "R1";
        cyc(1'b0, 4'b1111);
        for (int i = 0; i < 6; i++) cyc(1'b0, 4'(i * 5));
        // every fixed condition pattern
        for (int p = 0; p < 16; p++) run(0, 4'(p), 0);
        // random conditions per cycle
        for (int r = 0; r < 60; r++) run(1, 4'($urandom), 0);
        // R2 restart colliding with branch or end step
        for (int k = 1; k <= 6; k++)
            for (int p = 0; p < 16; p++) run(0, 4'(p), k);
        for (int r = 0; r < 40; r++) run(1, 4'($urandom), 1 + (r % 5));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule